// File: doc/BRIEF.md
# Trigger Packet Header Stripper

This block sits between a packet receiver and a buffer memory. It takes decision packets as 32-bit words on a streaming bus with valid, ready and start-of-packet markers. Every packet starts with a fixed run of protocol header words, which are thrown away. A fixed run of payload words follows, and these carry the trigger decision. The payload words enter a small FIFO. The FIFO drains into an external memory through a synchronous write port, one word per accepted write. The event identifier sits in the low bits of the first payload word and selects an eight-word slot in the memory, so each event's decision lands at a place that depends only on its identifier.

If a packet is cut short by a new start-of-packet, it is abandoned. A one-cycle error pulse is raised, and the abandoned payload words that still wait in the FIFO are removed. When the last payload word of a packet has been written, a one-cycle completion pulse is raised together with the event identifier. When the FIFO is full the block deasserts its ready, and the upstream source holds its word until it is taken.

Top module: `trig_hdr_strip`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1 and `mem_we`, `len_err` and `evt_done` are 0.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. The accepted word with `in_sop` = 1 and the next nine accepted words are header words and cause no memory write. Words accepted with `in_sop` = 0 outside a packet, or after a packet's eighteenth word, are ignored and cause no write.
- R3: Payload word k (k = 0..7) is the (11+k)-th word of the packet. It is written with `mem_addr` = {event id, k[2:0]}, where the event id is bits [7:0] of payload word 0. Words are written in ascending k.
- R4: When the FIFO is empty, `mem_we` rises in the cycle after the edge that accepts a payload word. A write completes on an edge where `mem_we` and `mem_ready` are both 1.
- R5: The FIFO holds six payload words. `in_ready` is 0 while six words are held, and no accepted payload word is lost.
- R6: If `in_sop` is accepted before the previous packet reached eighteen words, `len_err` is 1 for the next cycle. Payload words of the cut packet that are still in the FIFO are never written, and no completion pulse is raised for that packet.
- R7: In the cycle after the write of payload word 7 completes, `evt_done` is 1 for one cycle and `evt_id` carries that packet's event id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Stream data word |
| in_valid | input | 1 | Stream word valid |
| in_sop | input | 1 | Marks the first word of a packet |
| in_ready | output | 1 | Block can take a word |
| mem_we | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory takes the write this cycle |
| mem_addr | output | 11 | Memory word address {event id, word index} |
| mem_wdata | output | 32 | Memory write data |
| len_err | output | 1 | Cut-short packet pulse |
| evt_done | output | 1 | Event fully stored pulse |
| evt_id | output | 8 | Event id qualified by evt_done |

## Verification
The write request follows the accepting edge of a payload word by one cycle when the FIFO is empty. `len_err` follows the accepting edge of the offending start word by one cycle. `evt_done` follows the edge that completes the last write by one cycle. `in_ready` falls one cycle after the sixth word is pushed into a FIFO that is not draining. The bench drives inputs on the falling edge and clears valid one nanosecond after each accepting edge. It checks these one-cycle results at the falling edge right after the edge that causes them. Memory contents and pulse counts are compared only after a drain window long enough for the slowest write-acceptance pattern. The bench sweeps every event id under four memory-acceptance patterns, and computes each expected slot word from the event id and a generation number.

// File: rtl/trig_strip_pkg.sv
`timescale 1ns/1ps
package trig_strip_pkg;

   // Receive phase of the packet parser
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_HDR  = 2'd1,
      PS_PAY  = 2'd2
   } parse_state_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tsh_parser.sv
`timescale 1ns/1ps
module tsh_parser
   import trig_strip_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned HDR_WORDS = 10,
   parameter int unsigned PAY_WORDS = 8,
   localparam int unsigned IDX_W    = $clog2(PAY_WORDS),
   localparam int unsigned POS_W    = $clog2(max_of(HDR_WORDS, PAY_WORDS)) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_ready,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic [IDX_W-1:0]  push_idx,
   output logic              abort,
   output logic [IDX_W:0]    abort_cnt,
   output logic              len_err
);

   parse_state_e     state;
   logic [POS_W-1:0] pos;
   logic             take;

   assign take      = in_valid && in_ready;
   assign push      = take && !in_sop && (state == PS_PAY);
   assign push_data = in_data;
   assign push_idx  = pos[IDX_W-1:0];
   assign abort     = take && in_sop && (state != PS_IDLE);
   assign abort_cnt = (abort && state == PS_PAY) ? (IDX_W+1)'(pos) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= PS_IDLE;
         pos     <= '0;
         len_err <= 1'b0;
      end else begin
         len_err <= abort;
         if (take) begin
            if (in_sop) begin
               state <= PS_HDR;
               pos   <= POS_W'(1);
            end else begin
               unique case (state)
                  PS_HDR: begin
                     if (pos == POS_W'(HDR_WORDS - 1)) begin
                        state <= PS_PAY;
                        pos   <= '0;
                     end else begin
                        pos <= pos + 1'b1;
                     end
                  end
                  PS_PAY: begin
                     if (pos == POS_W'(PAY_WORDS - 1)) begin
                        state <= PS_IDLE;
                        pos   <= '0;
                     end else begin
                        pos <= pos + 1'b1;
                     end
                  end
                  default: begin
                     state <= PS_IDLE;
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/tsh_fifo.sv
`timescale 1ns/1ps
module tsh_fifo #(
   parameter int unsigned W     = 35,
   parameter int unsigned DEPTH = 6,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   input  logic [CNT_W-1:0] drop_req,
   output logic [W-1:0]     rdata,
   output logic [CNT_W-1:0] cnt,
   output logic             full,
   output logic             empty
);

   localparam int unsigned XW = CNT_W + 1;

   logic [W-1:0]     slots [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_fwd, rd_fwd, wr_back;
   logic [CNT_W-1:0] after_pop, drop_n;

   assign after_pop = cnt - CNT_W'(pop);
   assign drop_n    = (drop_req < after_pop) ? drop_req : after_pop;
   assign full      = (cnt == CNT_W'(DEPTH));
   assign empty     = (cnt == '0);
   assign rdata     = slots[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_fwd  = wr_ptr + 1'b1;
         assign rd_fwd  = rd_ptr + 1'b1;
         assign wr_back = wr_ptr - PTR_W'(drop_n);
      end else begin : g_mod
         logic [XW-1:0] wide_wr, wide_back;
         assign wr_fwd    = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_fwd    = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wide_wr   = XW'(wr_ptr);
         assign wide_back = (wide_wr >= XW'(drop_n)) ? wide_wr - XW'(drop_n)
                                                     : wide_wr + XW'(DEPTH) - XW'(drop_n);
         assign wr_back   = PTR_W'(wide_back);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) slots[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (pop) rd_ptr <= rd_fwd;
         if (push)               wr_ptr <= wr_fwd;
         else if (drop_n != '0) wr_ptr <= wr_back;
         cnt <= after_pop + CNT_W'(push) - drop_n;
      end
   end

endmodule

// File: rtl/tsh_writer.sv
`timescale 1ns/1ps
module tsh_writer #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned EVID_W = 8,
   parameter int unsigned IDX_W  = 3,
   localparam int unsigned ADDR_W = EVID_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              avail,
   input  logic [DATA_W-1:0] head_data,
   input  logic [IDX_W-1:0]  head_idx,
   input  logic              mem_ready,
   output logic              pop,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              evt_done,
   output logic [EVID_W-1:0] evt_id
);

   logic [EVID_W-1:0] evid_q, evid_cur;
   logic              first_word, last_word;

   assign first_word = (head_idx == '0);
   assign last_word  = (head_idx == {IDX_W{1'b1}});
   assign evid_cur   = first_word ? head_data[EVID_W-1:0] : evid_q;
   assign mem_we     = avail;
   assign pop        = avail && mem_ready;
   assign mem_addr   = {evid_cur, head_idx};
   assign mem_wdata  = head_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evid_q   <= '0;
         evt_done <= 1'b0;
         evt_id   <= '0;
      end else begin
         evt_done <= pop && last_word;
         if (pop && first_word) evid_q <= head_data[EVID_W-1:0];
         if (pop && last_word)  evt_id <= evid_cur;
      end
   end

endmodule

// File: rtl/trig_hdr_strip.sv
`timescale 1ns/1ps
module trig_hdr_strip #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned HDR_WORDS  = 10,
   parameter int unsigned PAY_WORDS  = 8,
   parameter int unsigned FIFO_DEPTH = 6,
   parameter int unsigned EVID_W     = 8,
   localparam int unsigned IDX_W     = $clog2(PAY_WORDS),
   localparam int unsigned ADDR_W    = EVID_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_sop,
   output logic              in_ready,
   output logic              mem_we,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              len_err,
   output logic              evt_done,
   output logic [EVID_W-1:0] evt_id
);

   localparam int unsigned ENT_W = DATA_W + IDX_W;
   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);
   localparam int unsigned SAT_W = (IDX_W + 1 > CNT_W) ? IDX_W + 1 : CNT_W;

   generate
      if (HDR_WORDS < 2) begin : g_bad_hdr
         $error("HDR_WORDS must be at least 2");
      end
      if (PAY_WORDS < 2 || (PAY_WORDS & (PAY_WORDS - 1)) != 0) begin : g_bad_pay
         $error("PAY_WORDS must be a power of two of at least 2");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (EVID_W < 1 || EVID_W > DATA_W) begin : g_bad_evid
         $error("EVID_W must lie within the data word");
      end
   endgenerate

   logic              push, abort, fifo_full, fifo_empty, pop;
   logic [DATA_W-1:0] push_data;
   logic [IDX_W-1:0]  push_idx;
   logic [IDX_W:0]    abort_cnt;
   logic [CNT_W-1:0]  drop_req, fifo_cnt;
   logic [ENT_W-1:0]  head;
   logic [SAT_W-1:0]  abort_wide;

   assign in_ready   = !fifo_full;
   assign abort_wide = SAT_W'(abort_cnt);
   assign drop_req   = (abort_wide > SAT_W'(FIFO_DEPTH)) ? CNT_W'(FIFO_DEPTH)
                                                        : CNT_W'(abort_wide);

   tsh_parser #(
      .DATA_W   (DATA_W),
      .HDR_WORDS(HDR_WORDS),
      .PAY_WORDS(PAY_WORDS)
   ) u_parse (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (in_data),
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_ready (in_ready),
      .push     (push),
      .push_data(push_data),
      .push_idx (push_idx),
      .abort    (abort),
      .abort_cnt(abort_cnt),
      .len_err  (len_err)
   );

   tsh_fifo #(
      .W    (ENT_W),
      .DEPTH(FIFO_DEPTH)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .wdata   ({push_idx, push_data}),
      .pop     (pop),
      .drop_req(drop_req),
      .rdata   (head),
      .cnt     (fifo_cnt),
      .full    (fifo_full),
      .empty   (fifo_empty)
   );

   tsh_writer #(
      .DATA_W(DATA_W),
      .EVID_W(EVID_W),
      .IDX_W (IDX_W)
   ) u_write (
      .clk      (clk),
      .rst_n    (rst_n),
      .avail    (!fifo_empty),
      .head_data(head[DATA_W-1:0]),
      .head_idx (head[ENT_W-1:DATA_W]),
      .mem_ready(mem_ready),
      .pop      (pop),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .evt_done (evt_done),
      .evt_id   (evt_id)
   );

endmodule

// File: rtl/tsh_checker.sv
`timescale 1ns/1ps
module tsh_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned EVID_W = 8,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned DEPTH  = 6,
   parameter int unsigned CNT_W  = 3,
   localparam int unsigned ADDR_W = EVID_W + IDX_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_sop,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              len_err,
   input logic              evt_done,
   input logic [CNT_W-1:0]  fifo_cnt
);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CNT_W'(DEPTH)); // R5

   AST_HELD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !(mem_we && mem_ready)) |=> (fifo_cnt == $past(fifo_cnt))); // R5

   AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr[IDX_W-1:0] == '0) |->
         (mem_addr[ADDR_W-1:IDX_W] == mem_wdata[EVID_W-1:0])); // R3

   AST_LEN_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> $past(in_valid && in_ready && in_sop)); // R6

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |-> $past(mem_we && mem_ready && (&mem_addr[IDX_W-1:0]))); // R7

endmodule

bind trig_hdr_strip tsh_checker #(
   .DATA_W(DATA_W),
   .EVID_W(EVID_W),
   .IDX_W (IDX_W),
   .DEPTH (FIFO_DEPTH),
   .CNT_W (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_sop   (in_sop),
   .mem_we   (mem_we),
   .mem_ready(mem_ready),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .len_err  (len_err),
   .evt_done (evt_done),
   .fifo_cnt (fifo_cnt)
);

// File: tb/trig_hdr_strip_test.sv
`timescale 1ns/1ps
module trig_hdr_strip_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_sop = 1'b0;
   logic        in_ready;
   logic        mem_we;
   logic        mem_ready;
   logic [10:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        len_err;
   logic        evt_done;
   logic [7:0]  evt_id;

   int tests = 0;
   int fails = 0;
   int mode = 0;
   bit hold = 1'b0;
   int cyc = 0;
   int wr_count = 0;
   int done_count = 0;
   int err_count = 0;
   logic [7:0] last_id = '0;
   logic [31:0] bmem [0:2047];

   always #2.5 clk = ~clk;

   trig_hdr_strip uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (in_data),
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_ready (in_ready),
      .mem_we   (mem_we),
      .mem_ready(mem_ready),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .len_err  (len_err),
      .evt_done (evt_done),
      .evt_id   (evt_id)
   );

   // memory acceptance pattern
   always @(negedge clk) begin
      bit r;
      cyc <= cyc + 1;
      case (mode)
         1:       r = cyc[0];
         2:       r = (cyc % 3 == 0);
         3:       r = (cyc[4:0] >= 5'd20);
         default: r = 1'b1;
      endcase
      mem_ready <= !hold && r;
   end

   // memory model
   always @(posedge clk) begin
      if (rst_n && mem_we && mem_ready) begin
         bmem[mem_addr] <= mem_wdata;
         wr_count <= wr_count + 1;
      end
   end

   // pulse monitor
   always @(negedge clk) begin
      if (rst_n && evt_done) begin
         done_count <= done_count + 1;
         last_id <= evt_id;
      end
      if (rst_n && len_err) err_count <= err_count + 1;
   end

   function automatic logic [31:0] pay(input int e, input int k, input int g);
      if (k == 0) return {8'(e) ^ 8'h3C, 8'(g), 8'h5A, 8'(e)};
      return {8'(g), 8'(k), 8'(e) ^ 8'hA5, 8'(e * k + g)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("[TB] FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic send_word(input logic [31:0] d, input bit s);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      in_sop   = s;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_sop   = 1'b0;
   endtask

   // words first..last of packet for event e, generation g
   task automatic send_range(input int e, input int g, input int first, input int last);
      for (int i = first; i <= last; i++) begin
         if (i < 10) send_word(32'hE000_0000 + 32'(e * 16 + i), i == 0);
         else        send_word(pay(e, i - 10, g), 1'b0);
      end
   endtask

   task automatic drain();
      repeat (80) @(negedge clk);
   endtask

   task automatic check_slot(input int e, input int g, input int upto, input int g_old, input string req);
      for (int k = 0; k < 8; k++) begin
         logic [31:0] exp;
         exp = (k < upto) ? pay(e, k, g) : pay(e, k, g_old);
         chk(bmem[{8'(e), 3'(k)}] === exp, req, 64'(bmem[{8'(e), 3'(k)}]), 64'(exp));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("[TB] FAIL R5 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int d0, w0, e0;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(in_ready === 1'b1 && mem_we === 1'b0 && len_err === 1'b0 && evt_done === 1'b0,
          "R1 reset", {in_ready, mem_we, len_err, evt_done}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready === 1'b1 && mem_we === 1'b0 && len_err === 1'b0 && evt_done === 1'b0,
          "R1 after reset", {in_ready, mem_we, len_err, evt_done}, 4'b1000);

      // R2: stray words outside a packet
      w0 = wr_count;
      for (int i = 0; i < 5; i++) send_word(32'h0000_0011 * 32'(i), 1'b0);
      drain();
      chk(wr_count == w0, "R2 stray words", wr_count, w0);

      // R4 latency and R3 address on first payload word
      send_range(5, 9, 0, 10);
      @(negedge clk);
      chk(mem_we === 1'b1, "R4 write one cycle after payload", mem_we, 1);
      chk(mem_addr === {8'd5, 3'd0}, "R3 first address", mem_addr, {8'd5, 3'd0});
      chk(mem_wdata === pay(5, 0, 9), "R3 first data", mem_wdata, pay(5, 0, 9));
      send_range(5, 9, 11, 17);
      drain();
      check_slot(5, 9, 8, 0, "R3 slot 5");
      chk(done_count == 1 && last_id == 8'd5, "R7 done pulse id", {done_count[7:0], last_id}, {8'd1, 8'd5});

      // R3 R7 sweep of every event id under four acceptance patterns
      d0 = done_count;
      for (int e = 0; e < 256; e++) begin
         mode = e % 4;
         send_range(e, 0, 0, 17);
      end
      drain();
      mode = 0;
      for (int e = 0; e < 256; e++) check_slot(e, 0, 8, 0, "R3 sweep");
      chk(done_count == d0 + 256, "R7 sweep count", done_count, d0 + 256);
      chk(last_id == 8'd255, "R7 sweep last id", last_id, 8'd255);

      // R5 backpressure with memory stalled
      hold = 1'b1;
      fork
         send_range(7, 1, 0, 17);
      join_none
      repeat (30) @(negedge clk);
      chk(in_ready === 1'b0, "R5 ready low when full", in_ready, 0);
      chk(mem_we === 1'b1 && mem_addr === {8'd7, 3'd0}, "R5 head held", mem_addr, {8'd7, 3'd0});
      hold = 1'b0;
      wait fork;
      drain();
      check_slot(7, 1, 8, 1, "R5 no loss");

      // R6 cut packet while memory flows
      d0 = done_count; e0 = err_count;
      send_range(20, 2, 0, 12);
      send_word(32'hE000_0000 + 32'(21 * 16), 1'b1);
      @(negedge clk);
      chk(len_err === 1'b1, "R6 len_err cycle", len_err, 1);
      send_range(21, 2, 1, 17);
      drain();
      check_slot(20, 2, 3, 0, "R6 partial kept, rest unwritten");
      check_slot(21, 2, 8, 0, "R6 next packet");
      chk(done_count == d0 + 1 && last_id == 8'd21, "R6 no done for cut", done_count - d0, 1);
      chk(err_count == e0 + 1, "R6 one pulse", err_count - e0, 1);

      // R6 cut packet with payload still queued
      d0 = done_count; w0 = wr_count;
      hold = 1'b1;
      send_range(30, 3, 0, 12);
      send_range(31, 3, 0, 0);
      hold = 1'b0;
      send_range(31, 3, 1, 17);
      drain();
      check_slot(30, 3, 0, 0, "R6 queued words removed");
      check_slot(31, 3, 8, 0, "R6 after removal");
      chk(wr_count == w0 + 8, "R6 write count", wr_count - w0, 8);
      chk(done_count == d0 + 1, "R7 one done", done_count - d0, 1);

      // R2 trailing words after eighteen are ignored; header-only cut
      w0 = wr_count; e0 = err_count;
      send_range(40, 4, 0, 17);
      for (int i = 0; i < 4; i++) send_word(pay(41, i, 4), 1'b0);
      send_range(42, 4, 0, 4);
      send_range(43, 4, 0, 17);
      drain();
      check_slot(40, 4, 8, 0, "R2 trailing");
      check_slot(41, 0, 8, 0, "R2 trailing not written");
      chk(wr_count == w0 + 16, "R2 header words unwritten", wr_count - w0, 16);
      chk(err_count == e0 + 1, "R6 header-only cut", err_count - e0, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule